// File: doc/BRIEF.md
# Interrupt Priority Comparator with Capture

This block decides, for a single processor, whether an interrupt must be raised. An upstream arbiter presents the priority and vector of the most urgent pending source. The block holds the processor's current-priority level and compares the two. It raises a registered request whenever the pending level is strictly above the current level. That can happen because a more urgent source appeared, or because the current level was lowered beneath a source that was already waiting.

Alongside the comparison, the block keeps a capture register that software reads as the acknowledge value. The capture latches the vector and priority of the first pending interrupt that beats the current level. It then freezes. A later, more urgent arrival cannot displace it until the current level is rewritten. When the processor acknowledges, the captured priority becomes the new current level and the old level is preempted.

The current level can be rewritten from three places: the acknowledge load, a pop from an external priority stack, and a direct software write. Any of these rewrites releases the capture, so the next cycle compares afresh against the new level.

Top module: `irq_prio_cmp`

## Requirements
- R1: While reset is high and on the first cycle after it, `cur_pri`, `irq_req`, `ack_vec` and `ack_pri` all read zero.
- R2: After each clock edge, `irq_req` is 1 exactly when the `pend_pri` value sampled at that edge is strictly greater, as an unsigned 4-bit number, than the `cur_pri` value produced by that same edge.
- R3: A pending priority of 0 never raises `irq_req` and is never captured.
- R4: When no capture is held and the current level is not being rewritten, a `pend_pri` strictly above `cur_pri` is captured at the clock edge, and `ack_vec`/`ack_pri` then show that vector and priority.
- R5: While a capture is held and no rewrite occurs, `ack_vec` and `ack_pri` stay unchanged, even if a higher `pend_pri` arrives.
- R6: An `ack` pulse while a capture is held loads `cur_pri` with the captured priority and releases the capture.
- R7: An `ack` pulse while no capture is held has no effect: `cur_pri` keeps its value.
- R8: A `pop_en` pulse loads `cur_pri` with `pop_pri` and releases the capture.
- R9: A `sw_wr_en` pulse loads `cur_pri` with `sw_wr_pri` and releases the capture.
- R10: When several rewrites coincide, an effective acknowledge wins over a pop, and a pop wins over a software write.
- R11: A capture is never taken in the cycle of a rewrite. `ack_vec` and `ack_pri` keep their old values across that edge, and the new comparison against the rewritten level takes effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_pri | input | 4 | Highest pending priority from the arbiter (0 = nothing) |
| pend_vec | input | VEC_W | Vector number belonging to `pend_pri` |
| ack | input | 1 | Interrupt acknowledge from the processor |
| pop_en | input | 1 | Priority-stack pop strobe |
| pop_pri | input | 4 | Priority returned by the stack pop |
| sw_wr_en | input | 1 | Software write strobe for the current level |
| sw_wr_pri | input | 4 | Value written by software |
| irq_req | output | 1 | Registered interrupt request to the processor |
| cur_pri | output | 4 | Current-priority register |
| ack_vec | output | VEC_W | Captured vector (acknowledge value) |
| ack_pri | output | 4 | Captured priority |

## Verification
Two functions can fall on the same edge: the capture wants to latch a freshly qualifying interrupt while a rewrite of the current level releases it. The bench provokes this by holding a qualifying pending level on the very cycle of an acknowledge, a pop or a software write. It then checks that the capture registers keep their old contents across that edge and load only on the next one. The three rewrite sources are also pulsed together in every combination, and the resulting level is judged against the fixed precedence order. Every pair of current and pending levels is swept with a bench model that computes the expected outputs arithmetically.

// File: rtl/irq_cmp_pkg.sv
package irq_cmp_pkg;

    localparam int PRI_W = 4;

    typedef logic [PRI_W-1:0] pri_t;

    // Source of a rewrite of the current level, in precedence order.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_ACK  = 2'd1,
        UPD_POP  = 2'd2,
        UPD_SW   = 2'd3
    } upd_src_e;

    // Strict unsigned comparison: does a pending level preempt the current one?
    function automatic logic outranks(input pri_t pending, input pri_t current);
        return pending > current;
    endfunction

    // Pick the winning rewrite source: acknowledge, then pop, then software.
    function automatic upd_src_e pick_src(input logic ack_take,
                                          input logic pop_req,
                                          input logic sw_req);
        upd_src_e s;
        if (ack_take)     s = UPD_ACK;
        else if (pop_req) s = UPD_POP;
        else if (sw_req)  s = UPD_SW;
        else              s = UPD_NONE;
        return s;
    endfunction

endpackage

// File: rtl/irq_cur_pri_reg.sv
module irq_cur_pri_reg
    import irq_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_take,
    input  pri_t ack_load,
    input  logic pop_en,
    input  pri_t pop_pri,
    input  logic sw_wr_en,
    input  pri_t sw_wr_pri,
    output pri_t cur_q,
    output pri_t cur_d,
    output logic upd
);

    upd_src_e src;

    always_comb begin
        src = pick_src(ack_take, pop_en, sw_wr_en);
        unique case (src)
            UPD_ACK:  cur_d = ack_load;
            UPD_POP:  cur_d = pop_pri;
            UPD_SW:   cur_d = sw_wr_pri;
            default:  cur_d = cur_q;
        endcase
        upd = (src != UPD_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= cur_d;
    end

endmodule

// File: rtl/irq_capture.sv
module irq_capture
    import irq_cmp_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  pri_t             pend_pri,
    input  logic [VEC_W-1:0] pend_vec,
    input  pri_t             cur_q,
    output logic             hold,
    output logic [VEC_W-1:0] vec_q,
    output pri_t             pri_q
);

    logic take;

    always_comb begin
        take = !hold && !upd && outranks(pend_pri, cur_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= 1'b0;
            vec_q <= '0;
            pri_q <= '0;
        end else if (upd) begin
            hold <= 1'b0;
        end else if (take) begin
            hold  <= 1'b1;
            vec_q <= pend_vec;
            pri_q <= pend_pri;
        end
    end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pri_t pend_pri,
    input  pri_t cur_d,
    output logic req_q
);

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= outranks(pend_pri, cur_d);
    end

endmodule

// File: rtl/irq_prio_cmp.sv
module irq_prio_cmp
    import irq_cmp_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       pend_pri,
    input  logic [VEC_W-1:0] pend_vec,
    input  logic             ack,
    input  logic             pop_en,
    input  logic [3:0]       pop_pri,
    input  logic             sw_wr_en,
    input  logic [3:0]       sw_wr_pri,
    output logic             irq_req,
    output logic [3:0]       cur_pri,
    output logic [VEC_W-1:0] ack_vec,
    output logic [3:0]       ack_pri
);

    pri_t cur_q;
    pri_t cur_d;
    logic upd;
    logic cap_hold;
    pri_t cap_pri;
    logic ack_take;

    assign ack_take = ack && cap_hold;

    irq_cur_pri_reg u_cur (
        .clk       (clk),
        .rst       (rst),
        .ack_take  (ack_take),
        .ack_load  (cap_pri),
        .pop_en    (pop_en),
        .pop_pri   (pop_pri),
        .sw_wr_en  (sw_wr_en),
        .sw_wr_pri (sw_wr_pri),
        .cur_q     (cur_q),
        .cur_d     (cur_d),
        .upd       (upd)
    );

    irq_capture #(.VEC_W(VEC_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .upd      (upd),
        .pend_pri (pend_pri),
        .pend_vec (pend_vec),
        .cur_q    (cur_q),
        .hold     (cap_hold),
        .vec_q    (ack_vec),
        .pri_q    (cap_pri)
    );

    irq_req_gen u_req (
        .clk      (clk),
        .rst      (rst),
        .pend_pri (pend_pri),
        .cur_d    (cur_d),
        .req_q    (irq_req)
    );

    assign cur_pri = cur_q;
    assign ack_pri = cap_pri;

endmodule

// File: rtl/irq_prio_cmp_chk.sv
module irq_prio_cmp_chk #(
    parameter int VEC_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       pend_pri,
    input logic [VEC_W-1:0] pend_vec,
    input logic             ack,
    input logic             pop_en,
    input logic             sw_wr_en,
    input logic             irq_req,
    input logic [3:0]       cur_pri,
    input logic [VEC_W-1:0] ack_vec,
    input logic [3:0]       ack_pri,
    input logic             cap_hold
);

    logic live;
    logic any_rw;

    assign any_rw = (ack && cap_hold) || pop_en || sw_wr_en;

    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    // R2
    a_r2_req_tracks: assert property (@(posedge clk) disable iff (rst)
        live |-> (irq_req == ($past(pend_pri) > cur_pri)));

    // R3
    a_r3_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (live && $past(pend_pri) == 4'd0) |-> !irq_req);

    // R4
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (!cap_hold && !any_rw && pend_pri > cur_pri) |=>
            (cap_hold && ack_vec == $past(pend_vec) && ack_pri == $past(pend_pri)));

    // R5
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        (cap_hold && !any_rw) |=> ($stable(ack_vec) && $stable(ack_pri)));

    // R6
    a_r6_ack_load: assert property (@(posedge clk) disable iff (rst)
        (ack && cap_hold) |=> (cur_pri == $past(ack_pri) && !cap_hold));

    // R7
    a_r7_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (ack && !cap_hold && !pop_en && !sw_wr_en) |=> $stable(cur_pri));

    // R11
    a_r11_release: assert property (@(posedge clk) disable iff (rst)
        any_rw |=> (!cap_hold && $stable(ack_vec) && $stable(ack_pri)));

endmodule

bind irq_prio_cmp irq_prio_cmp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend_pri (pend_pri),
    .pend_vec (pend_vec),
    .ack      (ack),
    .pop_en   (pop_en),
    .sw_wr_en (sw_wr_en),
    .irq_req  (irq_req),
    .cur_pri  (cur_pri),
    .ack_vec  (ack_vec),
    .ack_pri  (ack_pri),
    .cap_hold (cap_hold)
);

// File: tb/irq_prio_cmp_tb_top.sv
`timescale 1ns/1ps
module irq_prio_cmp_tb_top;

    localparam int VW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    pend_pri = '0;
    logic [VW-1:0] pend_vec = '0;
    logic          ack = 1'b0;
    logic          pop_en = 1'b0;
    logic [3:0]    pop_pri = '0;
    logic          sw_wr_en = 1'b0;
    logic [3:0]    sw_wr_pri = '0;
    logic          irq_req;
    logic [3:0]    cur_pri;
    logic [VW-1:0] ack_vec;
    logic [3:0]    ack_pri;

    always #10 clk = ~clk;

    irq_prio_cmp #(.VEC_W(VW)) dut_i (
        .clk(clk), .rst(rst),
        .pend_pri(pend_pri), .pend_vec(pend_vec),
        .ack(ack), .pop_en(pop_en), .pop_pri(pop_pri),
        .sw_wr_en(sw_wr_en), .sw_wr_pri(sw_wr_pri),
        .irq_req(irq_req), .cur_pri(cur_pri),
        .ack_vec(ack_vec), .ack_pri(ack_pri)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    int m_cur = 0, m_pri = 0, m_vec = 0, m_irq = 0;
    bit m_hold = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "irq_req", int'(irq_req), m_irq);
        chk(tag, "cur_pri", int'(cur_pri), m_cur);
        chk(tag, "ack_vec", int'(ack_vec), m_vec);
        chk(tag, "ack_pri", int'(ack_pri), m_pri);
    endtask

    // One clock: inputs already set; model advances; check at falling edge.
    task automatic step(input string tag);
        int nxt;
        bit rw;
        @(posedge clk);
        rw = 1'b1;
        if (ack && m_hold)  nxt = m_pri;
        else if (pop_en)    nxt = int'(pop_pri);
        else if (sw_wr_en)  nxt = int'(sw_wr_pri);
        else begin nxt = m_cur; rw = 1'b0; end
        if (rw) m_hold = 1'b0;
        else if (!m_hold && int'(pend_pri) > m_cur) begin
            m_hold = 1'b1;
            m_vec  = int'(pend_vec);
            m_pri  = int'(pend_pri);
        end
        m_irq = (int'(pend_pri) > nxt) ? 1 : 0;
        m_cur = nxt;
        @(negedge clk);
        check_all(tag);
        ack = 1'b0; pop_en = 1'b0; sw_wr_en = 1'b0;
    endtask

    task automatic sw_set(input int v, input string tag);
        sw_wr_en = 1'b1; sw_wr_pri = 4'(v);
        step(tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pend_pri = 4'd9; pend_vec = 9'd77;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        pend_pri = 4'd0; pend_vec = '0;
        rst = 1'b0;
        step("R1");

        // Sweep every current level against every pending level.
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 16; p++) begin
                pend_pri = 4'd0;
                sw_set(c, "R9");
                pend_pri = 4'(p); pend_vec = VW'(c * 16 + p + 3);
                step(p == 0 ? "R3" : (p > c ? "R4" : "R2"));
                step("R5");
                ack = 1'b1;
                step(p > c ? "R6" : "R7");
                step("R2");
            end
        end

        // Frozen capture against a later, higher arrival.
        pend_pri = 4'd0;
        sw_set(2, "R9");
        pend_pri = 4'd5; pend_vec = 9'd100;
        step("R4");
        pend_pri = 4'd9; pend_vec = 9'd200;
        step("R5"); step("R5"); step("R5");
        ack = 1'b1;
        step("R6");
        step("R11");
        step("R5");

        // Rewrite in the same cycle as a qualifying arrival.
        pend_pri = 4'd0;
        sw_set(1, "R9");
        pend_pri = 4'd7; pend_vec = 9'd311;
        pop_en = 1'b1; pop_pri = 4'd3;
        step("R11");
        step("R4");
        pend_pri = 4'd12; pend_vec = 9'd400;
        sw_wr_en = 1'b1; sw_wr_pri = 4'd0;
        step("R11");
        step("R4");

        // Pops alone, including an empty-stack zero.
        pop_en = 1'b1; pop_pri = 4'd0;
        step("R8");
        pop_en = 1'b1; pop_pri = 4'd14;
        step("R8");
        step("R2");

        // Coinciding rewrites in every combination with and without a capture.
        for (int k = 0; k < 8; k++) begin
            for (int h = 0; h < 2; h++) begin
                pend_pri = 4'd0;
                sw_set(4, "R9");
                if (h == 1) begin
                    pend_pri = 4'd10; pend_vec = VW'(50 + k);
                    step("R4");
                end
                pend_pri = 4'd13; pend_vec = 9'd500;
                ack = k[0]; pop_en = k[1]; pop_pri = 4'd6;
                sw_wr_en = k[2]; sw_wr_pri = 4'd8;
                step("R10");
                step("R2");
            end
        end

        pend_pri = 4'd0;
        step("R3");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule